// File: doc/BRIEF.md
# Register-Write Transmit Queue Adapter

This block lets a host bridge deliver outgoing packets to a CPU transmit queue by using nothing more than ordinary 32-bit register writes. The bridge presents a one-clock request strobe with a read/write flag, a 27-bit address and a data word. Writes aimed at the transmit-queue data register are steered into the queue. All other traffic is left alone, and that includes reads of that same register.

Each packet opens with a header word that carries its byte length in the low bits. The adapter keeps that word and does not forward it. It then forwards the payload words one at a time, each with a 4-bit control field. The control field stays zero until the final word of the packet, where it gives the count of valid bytes in that word. A registered write-ready output tells the bridge whether the adapter will take a word. It drops while the queue signals that it is nearly full.

Top module: `regwr_txq_adapter`

## Requirements
- R1: While reset is held, and on the first sampling point after reset, `qWr` is 0. `hostWrRdy` is 0 during reset and becomes 1 one clock after reset is released, provided `qNearlyFull` is 0.
- R2: The adapter is awaiting a header when it leaves reset and after each packet's final word. An accepted write while awaiting a header is not forwarded. Its low 16 bits load the packet's byte length.
- R3: An accepted payload write raises `qWr` for exactly one clock, on the clock edge after the request, and carries the written 32-bit word on `qWrData`. A write is accepted when `hostReq`=1, `hostRdWrN`=0, `hostAddr` equals `TXQ_ADDR` (default 27'h0000400) and `hostWrRdy`=1.
- R4: A forwarded word that is not the packet's final word has `qWrCtrl` = 0.
- R5: The final word of a packet (remaining bytes 4 or fewer) has `qWrCtrl` equal to the valid byte count, encoded 1, 2, 3 or 4. The next accepted write is then treated as a header.
- R6: A read request (`hostRdWrN`=1) to the queue address forwards nothing and leaves the packet position unchanged.
- R7: A write to any address other than `TXQ_ADDR` forwards nothing and leaves the packet position unchanged.
- R8: `hostWrRdy` is the inverse of `qNearlyFull`, delayed by one clock.
- R9: A request that arrives while `hostWrRdy` is 0 is dropped. It forwards nothing and leaves the packet position unchanged.
- R10: Accepted writes may arrive on consecutive clocks or be spaced by idle clocks, such as one word every three clocks. Every word is handled.
- R11: A header with length 0 is discarded, and the adapter goes on awaiting a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | One-clock register access strobe |
| hostRdWrN | input | 1 | 1 = read, 0 = write |
| hostAddr | input | 27 | Register address |
| hostData | input | 32 | Write data |
| hostWrRdy | output | 1 | Adapter accepts register writes |
| qNearlyFull | input | 1 | Transmit queue nearly full |
| qWr | output | 1 | Queue write strobe |
| qWrData | output | 32 | Queue write data |
| qWrCtrl | output | 4 | End-of-packet valid byte count, 0 before the last word |

## Verification
There is exactly one register between the inputs and each output. A request driven before a rising edge shows up on `qWr`, `qWrData` and `qWrCtrl` right after that edge. A change on `qNearlyFull` shows up on `hostWrRdy` right after the next edge. The bench drives every input on the falling edge and samples the outputs on the following falling edge, so each result is read one edge after its cause. Requests that must be ignored are checked the same way: the bench reads `qWr` one edge later. It then confirms that the packet position did not move by checking the control value of the next payload word.

// File: rtl/regwr_txq_pkg.sv
package regwr_txq_pkg;
  typedef struct packed {
    logic       push;      // forward current word to queue
    logic       last;      // current word closes the packet
    logic [2:0] tailBytes; // valid bytes in the closing word (1..4)
  } txqStrobe_t;
endpackage

// File: rtl/regwr_txq_ctrl.sv
module regwr_txq_ctrl
  import regwr_txq_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int LEN_W  = 16,
  parameter logic [ADDR_W-1:0] TXQ_ADDR = 27'h0000400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostRdWrN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [LEN_W-1:0]  lenField,
  input  logic              qNearlyFull,
  output logic              hostWrRdy,
  output txqStrobe_t        strobe
);
  localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

  logic             awaitLen;
  logic [LEN_W-1:0] remaining;
  logic             accept;

  assign accept = hostReq && !hostRdWrN && (hostAddr == TXQ_ADDR) && hostWrRdy;

  always_comb begin
    strobe.push      = accept && !awaitLen;
    strobe.last      = strobe.push && (remaining <= WORD_BYTES);
    strobe.tailBytes = strobe.last ? remaining[2:0] : 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostWrRdy <= 1'b0;
      awaitLen  <= 1'b1;
      remaining <= '0;
    end else begin
      hostWrRdy <= !qNearlyFull;
      if (accept) begin
        if (awaitLen) begin
          if (lenField != '0) begin
            remaining <= lenField;
            awaitLen  <= 1'b0;
          end
        end else if (strobe.last) begin
          remaining <= '0;
          awaitLen  <= 1'b1;
        end else begin
          remaining <= remaining - WORD_BYTES;
        end
      end
    end
  end

  // R8: ready follows the inverse of nearly-full one clock later
  p_ready_tracks_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    qNearlyFull |=> !hostWrRdy);
  // R9: requests while not ready never push
  p_blocked_no_push_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostWrRdy) |-> !strobe.push);
  // R2: a live packet always has bytes left
  p_remaining_live_r2: assert property (@(posedge clk) disable iff (!rstN)
    !awaitLen |-> (remaining != '0));
  // R11: a zero header keeps the adapter awaiting a header
  p_zero_len_r11: assert property (@(posedge clk) disable iff (!rstN)
    (accept && awaitLen && lenField == '0) |=> awaitLen);
endmodule

// File: rtl/regwr_txq_datapath.sv
module regwr_txq_datapath
  import regwr_txq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostRdWrN,
  input  logic [DATA_W-1:0] hostData,
  input  txqStrobe_t        strobe,
  output logic              qWr,
  output logic [DATA_W-1:0] qWrData,
  output logic [CTRL_W-1:0] qWrCtrl
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qWr     <= 1'b0;
      qWrData <= '0;
      qWrCtrl <= '0;
    end else begin
      qWr <= strobe.push;
      if (strobe.push) begin
        qWrData <= hostData;
        qWrCtrl <= strobe.last ? CTRL_W'(strobe.tailBytes) : '0;
      end
    end
  end

  // R3: forwarded data equals the word written one clock earlier
  p_data_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    qWr |-> (qWrData == $past(hostData)));
  // R3: no request, no queue write on the next clock
  p_idle_no_push_r3: assert property (@(posedge clk) disable iff (!rstN)
    !hostReq |=> !qWr);
  // R6: reads never reach the queue
  p_read_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && hostRdWrN) |=> !qWr);
  // R5: control field stays within 0..4
  p_ctrl_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    qWr |-> (qWrCtrl <= CTRL_W'(4)));
endmodule

// File: rtl/regwr_txq_adapter.sv
module regwr_txq_adapter
  import regwr_txq_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4,
  parameter int LEN_W  = 16,
  parameter logic [ADDR_W-1:0] TXQ_ADDR = 27'h0000400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostRdWrN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  output logic              hostWrRdy,
  input  logic              qNearlyFull,
  output logic              qWr,
  output logic [DATA_W-1:0] qWrData,
  output logic [CTRL_W-1:0] qWrCtrl
);
  txqStrobe_t strobe;

  regwr_txq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TXQ_ADDR(TXQ_ADDR)) ctrlInst (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostRdWrN(hostRdWrN),
    .hostAddr(hostAddr), .lenField(hostData[LEN_W-1:0]),
    .qNearlyFull(qNearlyFull), .hostWrRdy(hostWrRdy), .strobe(strobe)
  );

  regwr_txq_datapath #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) dpInst (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostRdWrN(hostRdWrN),
    .hostData(hostData), .strobe(strobe),
    .qWr(qWr), .qWrData(qWrData), .qWrCtrl(qWrCtrl)
  );
endmodule

// File: tb/regwr_txq_adapter_test.sv
module regwr_txq_adapter_test;
  localparam logic [26:0] QADDR = 27'h0000400;
  localparam logic [26:0] OTHER = 27'h0000404;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostRdWrN = 1'b1;
  logic [26:0] hostAddr = '0;
  logic [31:0] hostData = '0;
  logic        hostWrRdy;
  logic        qNearlyFull = 1'b0;
  logic        qWr;
  logic [31:0] qWrData;
  logic [3:0]  qWrCtrl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  regwr_txq_adapter uut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostRdWrN(hostRdWrN),
    .hostAddr(hostAddr), .hostData(hostData), .hostWrRdy(hostWrRdy),
    .qNearlyFull(qNearlyFull), .qWr(qWr), .qWrData(qWrData), .qWrCtrl(qWrCtrl)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge, sample the result one edge later.
  task automatic pushWord(input string req, input logic [26:0] addr, input logic rd,
                          input logic [31:0] data, input logic expWr,
                          input logic [3:0] expCtrl);
    hostReq = 1'b1; hostRdWrN = rd; hostAddr = addr; hostData = data;
    @(negedge clk);
    hostReq = 1'b0; hostRdWrN = 1'b1;
    check({req, " qWr"}, 64'(qWr), 64'(expWr));
    if (expWr) begin
      check({req, " data"}, 64'(qWrData), 64'(data));
      check({req, " ctrl"}, 64'(qWrCtrl), 64'(expCtrl));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    idle(2);
    check("R1 ready in reset", 64'(hostWrRdy), 64'(0));
    check("R1 qWr in reset", 64'(qWr), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 64'(hostWrRdy), 64'(1));
    check("R1 qWr after reset", 64'(qWr), 64'(0));
  endtask

  task automatic testSpaced();  // 10 bytes, one word every three clocks
    pushWord("R2 header", QADDR, 1'b0, 32'd10, 1'b0, 4'd0); idle(2);
    pushWord("R4 word0 R10", QADDR, 1'b0, 32'hA0A1A2A3, 1'b1, 4'd0); idle(2);
    pushWord("R4 word1 R10", QADDR, 1'b0, 32'hB0B1B2B3, 1'b1, 4'd0); idle(2);
    pushWord("R5 tail 2", QADDR, 1'b0, 32'hC0C1C2C3, 1'b1, 4'd2);
  endtask

  task automatic testBackToBack();  // 8 bytes, consecutive clocks
    pushWord("R5 next is header", QADDR, 1'b0, 32'd8, 1'b0, 4'd0);
    pushWord("R10 b2b word0", QADDR, 1'b0, 32'h11112222, 1'b1, 4'd0);
    pushWord("R5 tail 4", QADDR, 1'b0, 32'h33334444, 1'b1, 4'd4);
  endtask

  task automatic testForeign();  // 5 bytes with foreign traffic mid-packet
    pushWord("R2 header5", QADDR, 1'b0, 32'd5, 1'b0, 4'd0);
    pushWord("R6 read ignored", QADDR, 1'b1, 32'hDEADBEEF, 1'b0, 4'd0);
    pushWord("R7 other addr", OTHER, 1'b0, 32'hFEEDFACE, 1'b0, 4'd0);
    pushWord("R6 R7 word0", QADDR, 1'b0, 32'h55667788, 1'b1, 4'd0);
    pushWord("R7 other again", OTHER, 1'b0, 32'h01020304, 1'b0, 4'd0);
    pushWord("R5 tail 1", QADDR, 1'b0, 32'h99AABBCC, 1'b1, 4'd1);
  endtask

  task automatic testFull();
    pushWord("R2 header3", QADDR, 1'b0, 32'd3, 1'b0, 4'd0);
    qNearlyFull = 1'b1;
    check("R8 ready same cycle", 64'(hostWrRdy), 64'(1));
    @(negedge clk);
    check("R8 ready dropped", 64'(hostWrRdy), 64'(0));
    pushWord("R9 blocked", QADDR, 1'b0, 32'h77777777, 1'b0, 4'd0);
    qNearlyFull = 1'b0;
    @(negedge clk);
    check("R8 ready back", 64'(hostWrRdy), 64'(1));
    pushWord("R9 state kept tail 3", QADDR, 1'b0, 32'h12345678, 1'b1, 4'd3);
  endtask

  task automatic testZeroLen();
    pushWord("R11 zero header", QADDR, 1'b0, 32'd0, 1'b0, 4'd0);
    pushWord("R11 real header", QADDR, 1'b0, 32'd4, 1'b0, 4'd0);
    pushWord("R11 tail 4", QADDR, 1'b0, 32'hCAFEF00D, 1'b1, 4'd4);
    idle(1);
    check("R3 single-clock strobe", 64'(qWr), 64'(0));
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testSpaced();
    testBackToBack();
    testForeign();
    testFull();
    testZeroLen();
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule